// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM out of power-up before any normal access. After reset it turns on the memory clock enable and holds the bus idle for a power-up settling interval. It then closes every bank, runs a configurable burst of auto-refresh cycles, and writes a fixed operating configuration into the device mode register. Each step waits its own cycle count before the next command is placed on the bus.

When the last wait has elapsed the block raises a sticky ready flag. From then on it emits a one-cycle refresh request at a fixed interval for whatever controller owns the memory afterwards. All waits are compile-time parameters counted in clock cycles. The power-up interval can therefore be shortened for simulation and set to about 100 us of real clocks in silicon. The default is 8400 cycles at 84 MHz. Every output is driven from a register.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high the outputs hold `mem_cke`=0, command {cs_n,ras_n,cas_n,we_n}=0111 (NOP), `mem_ba`=0, `mem_addr`=0, `init_done`=0 and `refresh_req`=0.
- R2: `mem_cke` rises on the first clock edge after `rst` falls and stays high until the next reset.
- R3: The Precharge All command appears `PWRUP_CYC` cycles after `mem_cke` rises. It is encoded as command 0010 with `mem_addr` bit 10 set, all other address bits 0 and `mem_ba`=00.
- R4: `NUM_AREF` Auto Refresh commands (0001, address and bank 0) follow. The first comes `T_RP` cycles after the precharge, and each later one comes `T_RC` cycles after the one before it.
- R5: Load Mode Register (0000, `mem_ba`=00) comes `T_RC` cycles after the last refresh. It carries `mem_addr`=0x221: burst length field [2:0]=001, sequential burst type bit 3=0, CAS latency field [6:4]=010, operating mode field [8:7]=00 and single-location write bit 9=1.
- R6: `init_done` rises exactly `T_MRD` cycles after the Load Mode Register cycle and stays high until reset.
- R7: Every other cycle carries NOP (0111) with address and bank 0, and this includes every cycle after `init_done` is set. Each command lasts a single cycle.
- R8: `refresh_req` is a one-cycle pulse. The first comes `REF_PERIOD` cycles after `init_done` rises, and pulses repeat every `REF_PERIOD` cycles after that. It is never high while `init_done` is low.
- R9: A reset asserted in the middle of the sequence drops `mem_cke` and `init_done`. On release the whole sequence restarts from the clock-enable step with full spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the memory command clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus, carries A10 and mode word |
| init_done | output | 1 | Sequence complete, sticky |
| refresh_req | output | 1 | Periodic one-cycle refresh request |

## Verification
The bench checks exact command spacing cycle by cycle. A design with an off-by-one in the wait counter would put the precharge, a refresh or the mode load one cycle early or late. A design that miscounts the refresh burst would issue one refresh too many or too few, which moves the mode load. The mode word is compared bit for bit, so a field at the wrong position shows up at once. The bench also resets the block between two refreshes to confirm that the sequence restarts cleanly rather than resuming. It follows the refresh interval across several periods after completion, where a timer that reloads wrongly would drift or double-pulse.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command codes on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  // Address bit that selects all banks on precharge
  localparam int ALLBANK_BIT = 10;

  // Mode register fields
  localparam logic [2:0] MR_BURST_LEN  = 3'b001;
  localparam logic       MR_BURST_INTL = 1'b0;
  localparam logic [2:0] MR_CAS_LAT    = 3'b010;
  localparam logic [1:0] MR_OP_MODE    = 2'b00;
  localparam logic       MR_WR_SINGLE  = 1'b1;

  function automatic logic [11:0] mode_word();
    return {2'b00, MR_WR_SINGLE, MR_OP_MODE, MR_CAS_LAT, MR_BURST_INTL, MR_BURST_LEN};
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R4
  early_issue_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> zero);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC = 8400,
  parameter int T_RP      = 2,
  parameter int T_RC      = 6,
  parameter int T_MRD     = 2,
  parameter int NUM_AREF  = 5,
  parameter int CW        = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cke_on,
  output logic          cmd_issue,
  output sdr_cmd_e      cmd_kind,
  output logic          done
);

  localparam int AW = (NUM_AREF > 1) ? $clog2(NUM_AREF) : 1;
  localparam logic [AW-1:0] AREF_LAST = AW'(NUM_AREF - 1);

  typedef enum logic [2:0] {
    ST_START, ST_PRE, ST_AREF, ST_LMR, ST_MRD, ST_RUN
  } seq_state_e;

  seq_state_e    st_q, st_d;
  logic [AW-1:0] aref_q, aref_d;
  logic          done_q, done_set;

  always_comb begin
    st_d      = st_q;
    aref_d    = aref_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cke_on    = 1'b0;
    cmd_issue = 1'b0;
    cmd_kind  = CMD_NOP;
    done_set  = 1'b0;
    unique case (st_q)
      ST_START: begin
        cke_on   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(PWRUP_CYC - 1);
        st_d     = ST_PRE;
      end
      ST_PRE: if (tmr_zero) begin
        cmd_issue = 1'b1;
        cmd_kind  = CMD_PRE;
        tmr_load  = 1'b1;
        tmr_val   = CW'(T_RP - 1);
        aref_d    = '0;
        st_d      = ST_AREF;
      end
      ST_AREF: if (tmr_zero) begin
        cmd_issue = 1'b1;
        cmd_kind  = CMD_AREF;
        tmr_load  = 1'b1;
        tmr_val   = CW'(T_RC - 1);
        if (aref_q == AREF_LAST) st_d = ST_LMR;
        else                     aref_d = aref_q + 1'b1;
      end
      ST_LMR: if (tmr_zero) begin
        cmd_issue = 1'b1;
        cmd_kind  = CMD_LMR;
        tmr_load  = 1'b1;
        tmr_val   = CW'(T_MRD - 1);
        st_d      = ST_MRD;
      end
      ST_MRD: if (tmr_zero) begin
        done_set = 1'b1;
        st_d     = ST_RUN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_START;
      aref_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      aref_q <= aref_d;
      done_q <= done_q | done_set;
    end
  end

  assign done = done_q;

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !cmd_issue);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_on,
  input  logic              issue,
  input  sdr_cmd_e          kind,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] mode_ext;

  generate
    if (ADDR_W >= 12) begin : g_mode_wide
      assign mode_ext = ADDR_W'(mode_word());
    end else begin : g_mode_narrow
      logic [11:0] mw;
      assign mw       = mode_word();
      assign mode_ext = mw[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    addr_d = '0;
    if (issue) begin
      unique case (kind)
        CMD_PRE: addr_d[ALLBANK_BIT] = 1'b1;
        CMD_LMR: addr_d = mode_ext;
        default: addr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b0;
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      if (cke_on) cke <= 1'b1;
      cmd  <= issue ? kind : CMD_NOP;
      ba   <= '0;
      addr <= addr_d;
    end
  end

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R3
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> cke);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_PERIOD = 1292
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);

  localparam int RW = $clog2(REF_PERIOD);
  localparam logic [RW-1:0] WRAP = RW'(REF_PERIOD - 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (cnt_q == WRAP) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= 1'b0;
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int PWRUP_CYC  = 8400,
  parameter int T_RP       = 2,
  parameter int T_RC       = 6,
  parameter int T_MRD      = 2,
  parameter int NUM_AREF   = 5,
  parameter int REF_PERIOD = 1292
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done,
  output logic              refresh_req
);

  localparam int G1     = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int G2     = (G1 > T_MRD) ? G1 : T_MRD;
  localparam int MAXGAP = (PWRUP_CYC > G2) ? PWRUP_CYC : G2;
  localparam int CW     = $clog2(MAXGAP + 1);

  logic          tmr_load, tmr_zero, cke_on, cmd_issue;
  logic [CW-1:0] tmr_val;
  sdr_cmd_e      cmd_kind;
  logic [3:0]    cmd_bus;

  sdram_init_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .NUM_AREF(NUM_AREF), .CW(CW)
  ) i_fsm (
    .clk(clk), .rst(rst), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .cke_on(cke_on), .cmd_issue(cmd_issue),
    .cmd_kind(cmd_kind), .done(init_done)
  );

  sdram_gap_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) i_drive (
    .clk(clk), .rst(rst), .cke_on(cke_on), .issue(cmd_issue), .kind(cmd_kind),
    .cke(mem_cke), .cmd(cmd_bus), .ba(mem_ba), .addr(mem_addr)
  );

  sdram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) i_refresh (
    .clk(clk), .rst(rst), .en(init_done), .pulse(refresh_req)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_bus;

  // R8
  refresh_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> init_done);

  // R7
  nop_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(init_done) |-> (cmd_bus == CMD_NOP && mem_addr == '0));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int PW   = 40;
  localparam int TRP  = 2;
  localparam int TRC  = 6;
  localparam int TMRD = 2;
  localparam int NA   = 5;
  localparam int REF  = 1292;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0]  mem_ba;
  logic [11:0] mem_addr;
  logic        init_done, refresh_req;

  sdram_init_seq #(.PWRUP_CYC(PW)) i_sdram_init_seq (
    .clk(clk), .rst(rst), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done),
    .refresh_req(refresh_req)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  int cycles = 0;
  bit seen_edge = 0;
  bit restarted = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    seen_edge <= 1'b1;
    if (rst) t <= 0;
    else     t <= t + 1;
  end

  // Reference model evaluated at each negedge from the cycle count t
  always @(negedge clk) begin
    if (seen_edge) begin
      int pre_t, aref0, lmr_t, done_t, exp_cmd, exp_addr;
      string ctag;
      pre_t  = 1 + PW;
      aref0  = pre_t + TRP;
      lmr_t  = aref0 + NA * TRC;
      done_t = lmr_t + TMRD;
      exp_cmd = 4'b0111; exp_addr = 0; ctag = restarted ? "R9/R7" : "R7";
      if (t == pre_t) begin
        exp_cmd = 4'b0010; exp_addr = 12'h400; ctag = restarted ? "R9/R3" : "R3";
      end else if (t >= aref0 && t < lmr_t && ((t - aref0) % TRC) == 0) begin
        exp_cmd = 4'b0001; ctag = restarted ? "R9/R4" : "R4";
      end else if (t == lmr_t) begin
        exp_cmd = 4'b0000; exp_addr = 12'h221; ctag = restarted ? "R9/R5" : "R5";
      end
      if (t == 0) ctag = "R1";
      check(ctag, {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, exp_cmd);
      check(ctag, mem_addr, exp_addr);
      check(ctag, mem_ba, 0);
      check((t == 0) ? "R1" : "R2", mem_cke, (t >= 1) ? 1 : 0);
      check((t == 0) ? "R1" : "R6", init_done, (t >= done_t) ? 1 : 0);
      check((t == 0) ? "R1" : "R8", refresh_req,
            (t > done_t && ((t - done_t) % REF) == 0) ? 1 : 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset partway through the refresh burst (R9)
    repeat (58) @(negedge clk);
    rst = 1'b1;
    restarted = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (1 + PW + TRP + NA * TRC + TMRD + 3 * REF + 20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule